// File: doc/BRIEF.md
# Two-Level Inclusive Write-Through Cache

This block models a two-level cache that is the only storage for a small word-addressed space. Requests carry a read or write flag, a word address and, for writes, a data word. Each level is set-associative with a parameter-selected number of sets and ways. One set gives a fully associative level, and one way gives a direct-mapped level. Both levels share the block size and the way count. Victims are picked by true least-recently-used order, kept as per-way age counters.

The outer level always contains every block held by the inner level. Every write goes to both levels. A block found only in the outer level is copied into the inner level. There is no memory behind the outer level. Each stored word carries a written flag. A block that falls out of both levels comes back as a fresh allocation, and every word in it reads as empty.

A request is taken in one cycle, looked up in the next, and answered in the cycle after that. The answer gives the data, hit or miss, and an empty flag for words never written.

Top module: `c2l_cache`

## Requirements
- R1: A request is taken on a clock edge where req_valid and req_ready are both high. req_ready is low for exactly the one cycle after that edge. rsp_valid is high for exactly one cycle, two edges after acceptance.
- R2: The address is split as follows: word offset = addr mod WORDS, block = addr / WORDS. For each level, set = block mod that level's sets and tag = block / sets. Defaults are WORDS=2, WAYS=2, inner level 2 sets, outer level 4 sets.
- R3: A read that hits the inner level returns the stored word with rsp_hit=1 and rsp_miss=0.
- R4: A read that misses the inner level but hits the outer level returns the outer level's word with rsp_hit=1. It also copies the block into the inner level.
- R5: A read that misses both levels gives rsp_miss=1, rsp_hit=0, rsp_empty=1 and rsp_data=0. It allocates the block, with all words unwritten, in both levels.
- R6: A read of a word not written since its block was last allocated gives rsp_empty=1 and rsp_data=0, even on a hit.
- R7: A write that hits either level updates both levels and reports rsp_hit=1, rsp_empty=0 and rsp_data equal to the written word. A later read returns that word.
- R8: A write that misses both levels installs the block in both levels with only the addressed word written. It reports rsp_miss=1 and rsp_empty=0. The other words of the block read as empty.
- R9: The victim way is the lowest-numbered invalid way, otherwise the least recently used way. Read hits in the inner level do not refresh the outer level's recency. Every other access refreshes recency in both levels.
- R10: When the outer level evicts a block, any inner-level copy of it is invalidated before the inner victim is chosen. A block lost from both levels reads back as a miss with rsp_empty=1.
- R11: WORDS, WAYS and both set counts must be powers of two. The outer set count must be no smaller than the inner one. These are checked at elaboration.
- R12: After reset, req_ready=1, rsp_valid=0, and every line in both levels is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response present (one cycle) |
| rsp_data | output | DATA_W | Word read or written; 0 when empty |
| rsp_hit | output | 1 | Block was found in either level |
| rsp_miss | output | 1 | Block was found in neither level |
| rsp_empty | output | 1 | Addressed word has never been written |

## Verification
The hardest case to reach from the ports is an outer-level eviction of a block that is still live in the inner level. Equal way counts, plus recency refreshed on most accesses, normally keep the two levels in step. The stimulus breaks that step by filling one outer set and then read-hitting the older block in the inner level. Those read hits leave its outer-level age untouched, so a third block that maps to the same outer set evicts it while it is still the inner level's most recent line. A read of that block's written word must then come back as a miss marked empty. A stale inner-level copy would instead return the old data as a hit. A long stretch of mixed random traffic over a few blocks is then compared against a behavioural model on every clock.

// File: rtl/c2l_pkg.sv
package c2l_pkg;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_LOOK = 1'b1
   } c2l_state_e;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/c2l_lru.sv
module c2l_lru #(
   parameter int WAYS = 2,
   localparam int AW = (WAYS > 1) ? $clog2(WAYS) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          touch,
   input  logic [AW-1:0] touch_way,
   output logic [AW-1:0] oldest
);

   logic [AW-1:0]   age_q [WAYS];
   logic [WAYS-1:0] is_old;

   // age 0 = most recent; ages stay a permutation of 0..WAYS-1
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int w = 0; w < WAYS; w++) age_q[w] <= AW'(w);
      end else if (touch) begin
         for (int w = 0; w < WAYS; w++) begin
            if (AW'(w) == touch_way)
               age_q[w] <= '0;
            else if (age_q[w] < age_q[touch_way])
               age_q[w] <= age_q[w] + 1'b1;
         end
      end
   end

   always_comb begin
      oldest = '0;
      for (int w = 0; w < WAYS; w++) begin
         is_old[w] = (age_q[w] == AW'(WAYS - 1));
         if (is_old[w]) oldest = AW'(w);
      end
   end

   assert_single_oldest_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(is_old) == 1);

endmodule

// File: rtl/c2l_level.sv
module c2l_level #(
   parameter int SETS   = 2,
   parameter int WAYS   = 2,
   parameter int WORDS  = 2,
   parameter int TAG_W  = 14,
   parameter int DATA_W = 32,
   localparam int IW = (SETS > 1) ? $clog2(SETS) : 1,
   localparam int AW = (WAYS > 1) ? $clog2(WAYS) : 1,
   localparam int LW = WORDS * DATA_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IW-1:0]    lk_idx,
   input  logic [TAG_W-1:0] lk_tag,
   output logic             hit,
   output logic [AW-1:0]    hit_way,
   output logic [LW-1:0]    hit_data,
   output logic [WORDS-1:0] hit_wr,
   output logic [AW-1:0]    vic_way,
   output logic             vic_valid,
   output logic [TAG_W-1:0] vic_tag,
   input  logic             kill_en,
   input  logic [TAG_W-1:0] kill_tag,
   input  logic             upd_en,
   input  logic [AW-1:0]    upd_way,
   input  logic [LW-1:0]    upd_data,
   input  logic [WORDS-1:0] upd_wr,
   input  logic             touch_en,
   input  logic [AW-1:0]    touch_way
);

   logic             vld_q  [SETS][WAYS];
   logic [TAG_W-1:0] tag_q  [SETS][WAYS];
   logic [LW-1:0]    data_q [SETS][WAYS];
   logic [WORDS-1:0] wr_q   [SETS][WAYS];

   logic [WAYS-1:0]  match;
   logic [WAYS-1:0]  eff_vld;
   logic [AW-1:0]    oldest_s [SETS];

   generate
      for (genvar s = 0; s < SETS; s++) begin : g_set_lru
         c2l_lru #(.WAYS(WAYS)) u_lru (
            .clk       (clk),
            .rst_n     (rst_n),
            .touch     (touch_en && (lk_idx == IW'(s))),
            .touch_way (touch_way),
            .oldest    (oldest_s[s])
         );
      end
   endgenerate

   always_comb begin
      hit     = 1'b0;
      hit_way = '0;
      for (int w = WAYS - 1; w >= 0; w--) begin
         match[w]   = vld_q[lk_idx][w] && (tag_q[lk_idx][w] == lk_tag);
         eff_vld[w] = vld_q[lk_idx][w] && !(kill_en && (tag_q[lk_idx][w] == kill_tag));
         if (match[w]) begin
            hit     = 1'b1;
            hit_way = AW'(w);
         end
      end
      hit_data = data_q[lk_idx][hit_way];
      hit_wr   = wr_q[lk_idx][hit_way];
   end

   // victim: lowest free way after any back-invalidation, else the oldest way
   always_comb begin
      logic found;
      found   = 1'b0;
      vic_way = oldest_s[lk_idx];
      for (int w = 0; w < WAYS; w++) begin
         if (!eff_vld[w] && !found) begin
            vic_way = AW'(w);
            found   = 1'b1;
         end
      end
      vic_valid = eff_vld[vic_way];
      vic_tag   = tag_q[lk_idx][vic_way];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) vld_q[s][w] <= 1'b0;
      end else begin
         if (kill_en)
            for (int w = 0; w < WAYS; w++)
               if (tag_q[lk_idx][w] == kill_tag) vld_q[lk_idx][w] <= 1'b0;
         if (upd_en) vld_q[lk_idx][upd_way] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (upd_en) begin
         tag_q[lk_idx][upd_way]  <= lk_tag;
         data_q[lk_idx][upd_way] <= upd_data;
         wr_q[lk_idx][upd_way]   <= upd_wr;
      end
   end

   assert_tag_unique_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(match));

endmodule

// File: rtl/c2l_cache.sv
module c2l_cache #(
   parameter int ADDR_W  = 16,
   parameter int DATA_W  = 32,
   parameter int WORDS   = 2,
   parameter int WAYS    = 2,
   parameter int L1_SETS = 2,
   parameter int L2_SETS = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_data,
   output logic              rsp_hit,
   output logic              rsp_miss,
   output logic              rsp_empty
);
   import c2l_pkg::*;

   localparam int OB    = $clog2(WORDS);
   localparam int OW    = (OB > 0) ? OB : 1;
   localparam int BW    = ADDR_W - OB;
   localparam int L1_IB = $clog2(L1_SETS);
   localparam int L2_IB = $clog2(L2_SETS);
   localparam int I1W   = (L1_IB > 0) ? L1_IB : 1;
   localparam int I2W   = (L2_IB > 0) ? L2_IB : 1;
   localparam int T1W   = BW - L1_IB;
   localparam int T2W   = BW - L2_IB;
   localparam int AW    = (WAYS > 1) ? $clog2(WAYS) : 1;
   localparam int LW    = WORDS * DATA_W;

   initial begin
      assert_param_pow2_R11: assert (is_pow2(WORDS) && is_pow2(WAYS) &&
                                     is_pow2(L1_SETS) && is_pow2(L2_SETS))
         else $error("cache geometry must use powers of two");
      assert_param_nest_R11: assert ((L2_SETS >= L1_SETS) && (OB + L2_IB < ADDR_W))
         else $error("outer level needs at least as many sets as the inner level");
   end

   c2l_state_e        state_q;
   logic              wr_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic              look;

   logic [BW-1:0]  blk;
   logic [OW-1:0]  off;
   logic [I1W-1:0] l1_idx;
   logic [T1W-1:0] l1_tag;
   logic [I2W-1:0] l2_idx;
   logic [T2W-1:0] l2_tag;

   logic             l1_hit, l2_hit, l1_vic_valid, l2_vic_valid;
   logic [AW-1:0]    l1_hit_way, l2_hit_way, l1_vic_way, l2_vic_way;
   logic [AW-1:0]    l1_upd_way, l2_upd_way;
   logic [LW-1:0]    l1_hit_data, l2_hit_data, src_data, new_data;
   logic [WORDS-1:0] l1_hit_wr, l2_hit_wr, src_wr, new_wr;
   logic [T1W-1:0]   l1_vic_tag, kill_tag;
   logic [T2W-1:0]   l2_vic_tag;
   logic [BW-1:0]    ev_blk;
   logic             kill_en;
   logic [DATA_W-1:0] sel_word;
   logic             sel_wr;

   assign look      = (state_q == ST_LOOK);
   assign req_ready = (state_q == ST_IDLE);

   // address split per level (R2)
   assign blk    = BW'(addr_q >> OB);
   assign off    = OW'(addr_q & ADDR_W'(WORDS - 1));
   assign l1_idx = I1W'(blk & BW'(L1_SETS - 1));
   assign l1_tag = T1W'(blk >> L1_IB);
   assign l2_idx = I2W'(blk & BW'(L2_SETS - 1));
   assign l2_tag = T2W'(blk >> L2_IB);

   // outer eviction: the lost block always falls in the same inner set (R10)
   assign ev_blk   = (BW'(l2_vic_tag) << L2_IB) | BW'(l2_idx);
   assign kill_tag = T1W'(ev_blk >> L1_IB);
   assign kill_en  = look && !l2_hit && l2_vic_valid;

   assign l1_upd_way = l1_hit ? l1_hit_way : l1_vic_way;
   assign l2_upd_way = l2_hit ? l2_hit_way : l2_vic_way;

   c2l_level #(.SETS(L1_SETS), .WAYS(WAYS), .WORDS(WORDS), .TAG_W(T1W), .DATA_W(DATA_W)) u_l1 (
      .clk       (clk),
      .rst_n     (rst_n),
      .lk_idx    (l1_idx),
      .lk_tag    (l1_tag),
      .hit       (l1_hit),
      .hit_way   (l1_hit_way),
      .hit_data  (l1_hit_data),
      .hit_wr    (l1_hit_wr),
      .vic_way   (l1_vic_way),
      .vic_valid (l1_vic_valid),
      .vic_tag   (l1_vic_tag),
      .kill_en   (kill_en),
      .kill_tag  (kill_tag),
      .upd_en    (look && (wr_q || !l1_hit)),
      .upd_way   (l1_upd_way),
      .upd_data  (new_data),
      .upd_wr    (new_wr),
      .touch_en  (look),
      .touch_way (l1_upd_way)
   );

   c2l_level #(.SETS(L2_SETS), .WAYS(WAYS), .WORDS(WORDS), .TAG_W(T2W), .DATA_W(DATA_W)) u_l2 (
      .clk       (clk),
      .rst_n     (rst_n),
      .lk_idx    (l2_idx),
      .lk_tag    (l2_tag),
      .hit       (l2_hit),
      .hit_way   (l2_hit_way),
      .hit_data  (l2_hit_data),
      .hit_wr    (l2_hit_wr),
      .vic_way   (l2_vic_way),
      .vic_valid (l2_vic_valid),
      .vic_tag   (l2_vic_tag),
      .kill_en   (1'b0),
      .kill_tag  ('0),
      .upd_en    (look && (wr_q || !l2_hit)),
      .upd_way   (l2_upd_way),
      .upd_data  (new_data),
      .upd_wr    (new_wr),
      .touch_en  (look && !(l1_hit && !wr_q)),
      .touch_way (l2_upd_way)
   );

   // line to write back into both levels: source line with the write merged in
   always_comb begin
      src_data = '0;
      src_wr   = '0;
      if (l1_hit) begin
         src_data = l1_hit_data;
         src_wr   = l1_hit_wr;
      end else if (l2_hit) begin
         src_data = l2_hit_data;
         src_wr   = l2_hit_wr;
      end
      new_data = src_data;
      new_wr   = src_wr;
      sel_word = '0;
      sel_wr   = 1'b0;
      for (int i = 0; i < WORDS; i++) begin
         if (wr_q && (off == OW'(i))) begin
            new_data[i*DATA_W +: DATA_W] = wdata_q;
            new_wr[i]                    = 1'b1;
         end
         if (off == OW'(i)) begin
            sel_word = new_data[i*DATA_W +: DATA_W];
            sel_wr   = new_wr[i];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         wr_q      <= 1'b0;
         addr_q    <= '0;
         wdata_q   <= '0;
         rsp_valid <= 1'b0;
         rsp_data  <= '0;
         rsp_hit   <= 1'b0;
         rsp_miss  <= 1'b0;
         rsp_empty <= 1'b0;
      end else begin
         rsp_valid <= look;
         if (look) begin
            state_q   <= ST_IDLE;
            rsp_hit   <= l1_hit || l2_hit;
            rsp_miss  <= !(l1_hit || l2_hit);
            rsp_empty <= !sel_wr;
            rsp_data  <= sel_wr ? sel_word : '0;
         end else if (req_valid) begin
            state_q <= ST_LOOK;
            wr_q    <= req_write;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
         end
      end
   end

   assert_rsp_two_after_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |-> ##2 rsp_valid);
   assert_busy_one_cycle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (!req_ready ##1 req_ready));
   assert_rsp_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);
   assert_hit_xor_miss_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_hit != rsp_miss));
   assert_inclusion_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (look && l1_hit) |-> l2_hit);
   assert_inner_victim_not_target_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (look && !l1_hit && l1_vic_valid) |-> (l1_vic_tag != l1_tag));
   assert_write_never_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && wr_q) |-> !rsp_empty);
   assert_read_miss_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_miss && !wr_q) |-> (rsp_empty && rsp_data == '0));

endmodule

// File: tb/sim_c2l_cache.sv
`timescale 1ns/1ps
module sim_c2l_cache;

   localparam int NWD = 2;
   localparam int NWY = 2;
   localparam int S1  = 2;
   localparam int S2  = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [15:0] req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic        req_ready, rsp_valid, rsp_hit, rsp_miss, rsp_empty;
   logic [31:0] rsp_data;

   always #2 clk = ~clk;

   c2l_cache #(.ADDR_W(16), .DATA_W(32), .WORDS(NWD), .WAYS(NWY),
               .L1_SETS(S1), .L2_SETS(S2)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_hit(rsp_hit),
      .rsp_miss(rsp_miss), .rsp_empty(rsp_empty));

   int n_chk = 0;
   int n_bad = 0;

   // behavioural model: level 0 inner, level 1 outer; mo holds ways in recency order
   bit          mv [2][S2][NWY];
   int          mt [2][S2][NWY];
   logic [31:0] md [2][S2][NWY][NWD];
   bit          mw [2][S2][NWY][NWD];
   int          mo [2][S2][NWY];

   function automatic int mfind(int l, int s, int t);
      for (int w = 0; w < NWY; w++) if (mv[l][s][w] && mt[l][s][w] == t) return w;
      return -1;
   endfunction

   function automatic int mvict(int l, int s);
      for (int w = 0; w < NWY; w++) if (!mv[l][s][w]) return w;
      return mo[l][s][NWY-1];
   endfunction

   function automatic void mtouch(int l, int s, int w);
      int p = 0;
      for (int i = 0; i < NWY; i++) if (mo[l][s][i] == w) p = i;
      for (int i = p; i > 0; i--) mo[l][s][i] = mo[l][s][i-1];
      mo[l][s][0] = w;
   endfunction

   function automatic void mfill(int l, int s, int w, int t, logic [31:0] nd [NWD], bit nw [NWD]);
      mv[l][s][w] = 1'b1;
      mt[l][s][w] = t;
      for (int i = 0; i < NWD; i++) begin
         md[l][s][w][i] = nd[i];
         mw[l][s][w][i] = nw[i];
      end
   endfunction

   task automatic model(input bit wr, input int addr, input logic [31:0] wd,
                        output bit eh, output bit em, output bit ee, output logic [31:0] ed);
      int blk = addr / NWD;
      int off = addr % NWD;
      int s1 = blk % S1, t1 = blk / S1, s2 = blk % S2, t2 = blk / S2;
      int h1 = mfind(0, s1, t1);
      int h2 = mfind(1, s2, t2);
      logic [31:0] nd [NWD];
      bit nw [NWD];
      for (int i = 0; i < NWD; i++) begin
         nd[i] = 32'h0;
         nw[i] = 1'b0;
         if (h1 >= 0) begin nd[i] = md[0][s1][h1][i]; nw[i] = mw[0][s1][h1][i]; end
         else if (h2 >= 0) begin nd[i] = md[1][s2][h2][i]; nw[i] = mw[1][s2][h2][i]; end
      end
      if (wr) begin nd[off] = wd; nw[off] = 1'b1; end
      eh = (h1 >= 0) || (h2 >= 0);
      em = !eh;
      ee = !nw[off];
      ed = nw[off] ? nd[off] : 32'h0;
      if (h2 < 0) begin
         int v = mvict(1, s2);
         if (mv[1][s2][v]) begin
            int evb = mt[1][s2][v] * S2 + s2;
            for (int w = 0; w < NWY; w++)
               if (mv[0][evb % S1][w] && mt[0][evb % S1][w] == evb / S1) mv[0][evb % S1][w] = 1'b0;
         end
         mfill(1, s2, v, t2, nd, nw);
         mtouch(1, s2, v);
      end else begin
         if (wr) mfill(1, s2, h2, t2, nd, nw);
         if (!(h1 >= 0 && !wr)) mtouch(1, s2, h2);
      end
      if (h1 < 0) begin
         int v = mvict(0, s1);
         mfill(0, s1, v, t1, nd, nw);
         mtouch(0, s1, v);
      end else begin
         if (wr) mfill(0, s1, h1, t1, nd, nw);
         mtouch(0, s1, h1);
      end
   endtask

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // called at a falling edge with the block idle; returns at the response's falling edge
   task automatic access(input string tag, input bit wr, input int addr, input logic [31:0] wd);
      bit eh, em, ee;
      logic [31:0] ed;
      chk("R1 ready before request", {63'b0, req_ready}, 64'd1);
      req_valid = 1'b1;
      req_write = wr;
      req_addr  = 16'(addr);
      req_wdata = wd;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R1 busy during lookup", {62'b0, req_ready, rsp_valid}, 64'd0);
      model(wr, addr, wd, eh, em, ee, ed);
      @(negedge clk);
      chk(tag, {28'b0, rsp_valid, rsp_hit, rsp_miss, rsp_empty, rsp_data},
               {28'b0, 1'b1, eh, em, ee, ed});
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         chk("R1 no response when idle", {63'b0, rsp_valid}, 64'd0);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      for (int l = 0; l < 2; l++)
         for (int s = 0; s < S2; s++)
            for (int w = 0; w < NWY; w++) begin
               mv[l][s][w] = 1'b0;
               mo[l][s][w] = w;
            end
      repeat (3) @(negedge clk);
      chk("R12 reset outputs", {62'b0, req_ready, rsp_valid}, 64'd2);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R12 ready after reset", {62'b0, req_ready, rsp_valid}, 64'd2);

      // block 8 = addresses 16,17; inner set 0, outer set 0
      access("R5 R12 cold read misses both", 1'b0, 16, 32'h0);
      access("R6 R3 read hit on unwritten word", 1'b0, 16, 32'h0);
      access("R7 write hit", 1'b1, 16, 32'h1111_1111);
      access("R7 R3 read back write", 1'b0, 16, 32'h0);
      access("R6 neighbour word still empty", 1'b0, 17, 32'h0);
      idle(2);
      // block 5 = addresses 10,11
      access("R8 write miss installs block", 1'b1, 11, 32'h2222_2222);
      access("R8 other word empty", 1'b0, 10, 32'h0);
      access("R8 written word returned", 1'b0, 11, 32'h0);
      access("R2 R7 overwrite", 1'b1, 11, 32'h2323_2323);
      access("R2 overwritten value", 1'b0, 11, 32'h0);
      // blocks 10 and 14 push block 8 out of the inner level only
      access("R9 fill inner set", 1'b0, 20, 32'h0);
      access("R9 evict inner LRU", 1'b0, 28, 32'h0);
      access("R4 outer hit promotes block", 1'b0, 16, 32'h0);
      access("R3 promoted block hits inner", 1'b0, 16, 32'h0);
      // block 12 fills outer set 0; inner read hits leave block 8 old in the outer level
      access("R9 second block in outer set", 1'b0, 24, 32'h0);
      access("R9 inner read hit no outer refresh", 1'b0, 16, 32'h0);
      access("R10 outer eviction of inner-live block", 1'b0, 32, 32'h0);
      access("R10 lost block returns empty", 1'b0, 16, 32'h0);
      access("R7 write miss then read", 1'b1, 6, 32'h3333_3333);
      access("R7 write-through value", 1'b0, 6, 32'h0);
      idle(1);

      for (int k = 0; k < 600; k++) begin
         int a = int'($urandom_range(0, 47));
         bit w = 1'($urandom_range(0, 1));
         access("R9 R10 mixed traffic", w, a, $urandom);
         if ($urandom_range(0, 7) == 0) idle(1);
      end
      idle(2);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule